// File: doc/BRIEF.md
# Adaptive-Width Delta Sample Encoder

This block compresses the sample stream of one digitiser channel. Each accepted 10-bit sample becomes one variable-length code word. The code word sits left-aligned in a 32-bit field and comes with a 5-bit count of its meaningful bits. A later packing stage concatenates these code words into output words.

The first sample of a channel goes out unchanged, behind a short marker. After that, each sample is replaced by its difference from the sample before it. The difference is written in two's complement with the fewest bits that can hold it. While that width stays the same, only the difference bits are sent. When the width changes, a small header carrying the new width comes first. A difference that would need ten or more bits is sent as a raw sample instead. Asserting the channel-start input together with a sample clears the history, so one encoder can serve several channels one after another.

Top module: `delta_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, outValid is 0, outCode is all zeros and outLen is 0.
- R2: outValid equals the inValid of the previous cycle, so each code word appears exactly one clock after its sample.
- R3: The first sample after reset is coded raw: outCode[31:27] = 5'b00001, outCode[26:17] = the sample, outCode[16:0] = 0, outLen = 15.
- R4: A sample presented with chanStart high is coded raw as in R3, whatever came before it. chanStart has no effect while inValid is low.
- R5: The delta is the current sample minus the previous sample, taken as a signed 11-bit value. Its width w is the smallest w >= 1 with -2^(w-1) <= delta <= 2^(w-1)-1.
- R6: If w < 10 and w differs from the width of the previous code word, outCode holds a 0 bit at bit 31, then w as 4 bits in [30:27], then the low w bits of the delta, MSB first, starting at bit 26. outLen = 5 + w.
- R7: If w < 10 and w equals the width of the previous code word, outCode holds only the low w bits of the delta, starting at bit 31. outLen = w.
- R8: If w >= 10, the sample is coded raw as in R3. A raw word counts as width 0 for the next sample, so the next non-raw word always carries a header.
- R9: In every code word, the bits below the top outLen bits are zero.
- R10: Cycles with inValid low change neither the stored previous sample nor the stored width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanStart | input | 1 | Marks the presented sample as the first of a channel |
| inValid | input | 1 | A sample is presented this cycle |
| inSample | input | 10 | Unsigned ADC sample |
| outValid | output | 1 | A code word is present |
| outCode | output | 32 | Code word, left-aligned |
| outLen | output | 5 | Number of meaningful bits in outCode |

## Verification
The bench uses the default parameters: 10-bit samples, a 32-bit code field and a 4-bit width field. With these, every width from 1 up to the raw cutoff at 10 can be reached by choosing sample pairs. The directed cases cover the edges of that range: a delta of zero, +1, -1, +255, +256, -256, -512 and the full-scale swing between 0 and 1023. A seeded random walk with mostly small steps, occasional jumps, idle gaps and channel restarts covers runs of equal widths and frequent header insertion.

// File: rtl/delta_enc_pkg.sv
package delta_enc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic take;    // accept the presented sample
    logic selRaw;  // emit raw code word
    logic selHdr;  // emit header plus delta
  } encStrobe_t;
endpackage

// File: rtl/delta_enc_ctrl.sv
module delta_enc_ctrl
  import delta_enc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WIDTH_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               chanStart,
  input  logic [WIDTH_W-1:0] needW,
  output encStrobe_t         strobe
);
  localparam logic [WIDTH_W-1:0] RAW_MIN = WIDTH_W'(SAMPLE_W);

  logic               firstPend;
  logic [WIDTH_W-1:0] prevW;
  logic               rawNow;

  always_comb begin
    rawNow        = chanStart || firstPend || (needW >= RAW_MIN);
    strobe.take   = inValid;
    strobe.selRaw = rawNow;
    strobe.selHdr = !rawNow && (needW != prevW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPend <= 1'b1;
      prevW     <= '0;
    end else if (inValid) begin
      firstPend <= 1'b0;
      prevW     <= rawNow ? '0 : needW;
    end
  end
endmodule

// File: rtl/delta_enc_dp.sv
module delta_enc_dp
  import delta_enc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 32,
  parameter int LEN_W    = 5,
  parameter int WIDTH_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] inSample,
  input  encStrobe_t          strobe,
  output logic [WIDTH_W-1:0]  needW,
  output logic                outValid,
  output logic [CODE_W-1:0]   outCode,
  output logic [LEN_W-1:0]    outLen
);
  localparam int DIFF_W  = SAMPLE_W + 1;
  localparam int RAW_LEN = WIDTH_W + 1 + SAMPLE_W;
  localparam int HDR_LEN = WIDTH_W + 1;

  logic [SAMPLE_W-1:0]      prevSample;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] shifted;
  logic [CODE_W-1:0]        mask;
  logic [CODE_W-1:0]        dBits;
  logic [CODE_W-1:0]        codeNext;
  logic [LEN_W-1:0]         lenNext;

  assign diff = $signed({1'b0, inSample}) - $signed({1'b0, prevSample});

  // smallest two's complement width holding diff
  always_comb begin
    needW   = WIDTH_W'(DIFF_W);
    shifted = '0;
    for (int w = DIFF_W; w >= 1; w--) begin
      shifted = diff >>> (w - 1);
      if (shifted == '0 || shifted == '1) needW = WIDTH_W'(w);
    end
  end

  always_comb begin
    mask  = (CODE_W'(1) << needW) - CODE_W'(1);
    dBits = CODE_W'($unsigned(diff)) & mask;
    if (strobe.selRaw) begin
      codeNext = CODE_W'({{WIDTH_W{1'b0}}, 1'b1, inSample}) << (CODE_W - RAW_LEN);
      lenNext  = LEN_W'(RAW_LEN);
    end else if (strobe.selHdr) begin
      codeNext = (CODE_W'({1'b0, needW}) << (CODE_W - HDR_LEN))
               | (dBits << (CODE_W - HDR_LEN - int'(needW)));
      lenNext  = LEN_W'(HDR_LEN) + LEN_W'(needW);
    end else begin
      codeNext = dBits << (CODE_W - int'(needW));
      lenNext  = LEN_W'(needW);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= '0;
      outValid   <= 1'b0;
      outCode    <= '0;
      outLen     <= '0;
    end else begin
      outValid <= strobe.take;
      if (strobe.take) begin
        prevSample <= inSample;
        outCode    <= codeNext;
        outLen     <= lenNext;
      end
    end
  end
endmodule

// File: rtl/delta_enc.sv
module delta_enc
  import delta_enc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 32,
  parameter int LEN_W    = 5,
  parameter int WIDTH_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanStart,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic                outValid,
  output logic [CODE_W-1:0]   outCode,
  output logic [LEN_W-1:0]    outLen
);
  encStrobe_t         strobe;
  logic [WIDTH_W-1:0] needW;

  delta_enc_ctrl #(.SAMPLE_W(SAMPLE_W), .WIDTH_W(WIDTH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .chanStart(chanStart),
    .needW(needW), .strobe(strobe)
  );

  delta_enc_dp #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .LEN_W(LEN_W),
                 .WIDTH_W(WIDTH_W)) u_dp (
    .clk(clk), .rstN(rstN), .inSample(inSample), .strobe(strobe),
    .needW(needW), .outValid(outValid), .outCode(outCode), .outLen(outLen)
  );
endmodule

// File: rtl/delta_enc_chk.sv
module delta_enc_chk #(
  parameter int SAMPLE_W = 10,
  parameter int CODE_W   = 32,
  parameter int LEN_W    = 5,
  parameter int WIDTH_W  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                chanStart,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inSample,
  input logic                outValid,
  input logic [CODE_W-1:0]   outCode,
  input logic [LEN_W-1:0]    outLen
);
  localparam int RAW_LEN = WIDTH_W + 1 + SAMPLE_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_START_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && chanStart) |=> (outLen == LEN_W'(RAW_LEN) &&
      outCode[CODE_W-1 -: WIDTH_W+1] == (WIDTH_W+1)'(1) &&
      outCode[CODE_W-WIDTH_W-2 -: SAMPLE_W] == $past(inSample))); // R4
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLen != '0 && outLen <= LEN_W'(RAW_LEN))); // R5
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outCode << outLen) == '0)); // R9
endmodule

bind delta_enc delta_enc_chk #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W),
  .LEN_W(LEN_W), .WIDTH_W(WIDTH_W)) u_chk (.*);

// File: tb/delta_enc_bench.sv
module delta_enc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanStart = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  inSample = '0;
  logic        outValid;
  logic [31:0] outCode;
  logic [4:0]  outLen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int refPrev = 0;
  int refW = 0;
  bit refFirst = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  delta_enc u_delta_enc (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // append n bits of v, MSB first, at cursor pos
  task automatic putBits(inout logic [31:0] c, inout int pos, input int v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      c[pos] = v[i];
      pos--;
    end
  endtask

  task automatic model(input int s, input bit start, output logic [31:0] c,
                       output int len, output string req);
    int d;
    int w;
    int pos;
    d = s - refPrev;
    w = 1;
    while (!(d >= -(1 << (w - 1)) && d <= (1 << (w - 1)) - 1)) w++;
    c = '0;
    pos = 31;
    if (refFirst || start || w >= 10) begin
      putBits(c, pos, 0, 4);
      putBits(c, pos, 1, 1);
      putBits(c, pos, s, 10);
      len = 15;
      req = refFirst ? "R3" : (start ? "R4" : "R8");
      refW = 0;
    end else if (w != refW) begin
      putBits(c, pos, 0, 1);
      putBits(c, pos, w, 4);
      putBits(c, pos, d, w);
      len = 5 + w;
      req = "R6";
      refW = w;
    end else begin
      putBits(c, pos, d, w);
      len = w;
      req = "R7";
    end
    refPrev = s;
    refFirst = 1'b0;
  endtask

  task automatic send(input int s, input bit start);
    logic [31:0] c;
    int len;
    string req;
    @(negedge clk);
    inValid = 1'b1;
    chanStart = start;
    inSample = 10'(s);
    model(s, start, c, len, req);
    @(posedge clk);
    #1;
    check("R2 valid", {31'b0, outValid}, 32'd1);
    check({req, " R5 code"}, outCode, c);
    check({req, " R5 len"}, {27'b0, outLen}, 32'(len));
  endtask

  task automatic idle(input bit start);
    @(negedge clk);
    inValid = 1'b0;
    chanStart = start;
    inSample = 10'($urandom_range(1023));
    @(posedge clk);
    #1;
    check("R2 idle", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    int s;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", {31'b0, outValid}, 32'd0);
    check("R1 code", outCode, 32'd0);
    check("R1 len", {27'b0, outLen}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after", {27'b0, outLen}, 32'd0);

    // directed corners
    send(500, 1'b0);   // R3 first raw
    send(501, 1'b0);   // +1 w=2 header
    send(502, 1'b0);   // same width
    send(502, 1'b0);   // delta 0 w=1
    send(501, 1'b0);   // -1 w=1 same
    idle(1'b1);        // R4 chanStart ignored while idle, R10
    send(756, 1'b0);   // +255 w=9
    send(1012, 1'b0);  // +256 w=10 raw R8
    send(756, 1'b0);   // -256 w=9 header after raw
    send(244, 1'b0);   // -512 raw
    send(0, 1'b0);
    send(1023, 1'b0);  // +1023 raw
    send(0, 1'b0);     // -1023 raw
    send(3, 1'b0);
    send(3, 1'b1);     // R4 restart
    send(4, 1'b0);

    // random walk
    s = 512;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(99);
      if (r < 5) idle(r[0]);
      else begin
        if (r < 10) s = $urandom_range(1023);
        else if (r < 60) s = s + $urandom_range(6) - 3;
        else s = s + $urandom_range(80) - 40;
        if (s < 0) s = 0;
        if (s > 1023) s = 1023;
        send(s, r == 99);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule